// File: doc/BRIEF.md
# Scanline display mode sequencer

This block sets the timing of a raster display controller. For each scanline it moves through three phases: a sprite-attribute search, a video-memory fetch and a horizontal blank. After the last visible line it enters one long vertical-blank phase and then starts the next frame. The host side drives a step enable and, with each step, the number of machine cycles that have elapsed since the previous step. The block adds that amount to a phase counter. A phase ends only when the counter, with the new amount already added, goes strictly above that phase's own limit.

When a phase ends, the counter returns to zero and any cycles above the limit are dropped. When a horizontal blank ends, the line number goes up by one. The new line number is then compared with the visible-line limit, and that compare decides whether the next line starts or vertical blank begins. The outputs give the current mode, the line number, and single-cycle pulses that mark entry into horizontal blank and entry into vertical blank. A downstream interrupt controller or renderer can use these pulses.

The states and their transitions:
- SEARCH goes to FETCH when the count is above 80.
- FETCH goes to HBLANK when the count is above 172.
- HBLANK goes to SEARCH when the count is above 204 and the incremented line is still below the limit. It goes to VBLANK instead when the incremented line has reached the limit.
- VBLANK goes to SEARCH when the count is above 4560, and the line returns to zero.

Top module: `scanline_seq`

## Requirements
- R1: After a synchronous reset, mode is SEARCH, line is 0 and both pulses are low. Mode codes are HBLANK=0, VBLANK=1, SEARCH=2 and FETCH=3.
- R2: While step_en is low, mode and line hold their values and no pulse is raised, whatever value step_cycles has.
- R3: A step adds step_cycles to the phase counter before the compare. A phase ends only when the sum is strictly greater than its limit, so a sum equal to the limit keeps the mode.
- R4: SEARCH moves to FETCH once the count exceeds 80. FETCH moves to HBLANK once the count exceeds 172.
- R5: HBLANK ends once the count exceeds 204. The line then increments, and if the new line is below 143 the mode becomes SEARCH.
- R6: If the incremented line is 143 or more, the mode becomes VBLANK and the line holds that value.
- R7: VBLANK ends once the count exceeds 4560. The line returns to 0 and the mode becomes SEARCH.
- R8: When a phase ends, the counter clears to zero and the cycles above the limit are dropped.
- R9: hblank_start is high for exactly one cycle, in the cycle after the step that enters HBLANK, and is low at all other times.
- R10: vblank_start is high for exactly one cycle, in the cycle after the step that enters VBLANK, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Take one step this cycle |
| step_cycles | input | 8 | Machine cycles elapsed for this step |
| mode | output | 2 | Current mode code |
| line | output | 8 | Current line number |
| hblank_start | output | 1 | One-cycle pulse on entry into HBLANK |
| vblank_start | output | 1 | One-cycle pulse on entry into VBLANK |

## Verification
The phase counter is internal, so its faults show up only through when the mode changes. A count that carries the excess, or that compares with greater-or-equal, makes the mode change one step early on the step that brings the count exactly to a limit or just past it. A bad line compare shows up at the end of the frame, about 430 steps after reset: either vertical blank begins one line off, or the line number fails to return to zero. Every pulse is checked in the cycle where it should be high and again in the cycle after, so a stuck or stretched pulse is caught at once.

// File: rtl/scanline_seq_pkg.sv
package scanline_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_FETCH  = 2'd3
    } scan_mode_e;

endpackage

// File: rtl/scan_phase_acc.sv
module scan_phase_acc #(
    parameter int CYC_W   = 8,
    parameter int PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [CYC_W-1:0]   inc,
    input  logic [PHASE_W-1:0] limit,
    output logic               expire
);

    logic [PHASE_W-1:0] count_q;
    logic [PHASE_W-1:0] sum;

    // the increment is added first, then the sum is compared
    assign sum    = count_q + PHASE_W'(inc);
    assign expire = step && (sum > limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (step) begin
            // the part of the count above the limit is dropped
            count_q <= expire ? '0 : sum;
        end
    end

endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
    parameter int LINE_W    = 8,
    parameter int VIS_LINES = 143
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              clr,
    output logic [LINE_W-1:0] line,
    output logic              last
);

    localparam logic [LINE_W:0] VIS_EXT = (LINE_W+1)'(VIS_LINES);

    logic [LINE_W-1:0] line_q;

    // true when the line after this one would not be visible
    assign last = (({1'b0, line_q} + 1'b1) >= VIS_EXT);
    assign line = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (clr) begin
            line_q <= '0;
        end else if (inc) begin
            line_q <= line_q + 1'b1;
        end
    end

endmodule

// File: rtl/scan_mode_fsm.sv
module scan_mode_fsm
    import scanline_seq_pkg::*;
#(
    parameter int PHASE_W = 14,
    parameter int LIM_SEARCH = 80,
    parameter int LIM_FETCH  = 172,
    parameter int LIM_HBLANK = 204,
    parameter int LIM_VBLANK = 4560
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               expire,
    input  logic               last_line,
    output scan_mode_e         state,
    output logic [PHASE_W-1:0] limit,
    output logic               line_inc,
    output logic               line_clr,
    output logic               hb_pulse,
    output logic               vb_pulse
);

    scan_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, limit of the current phase, line control
    always_comb begin
        state_d  = state_q;
        limit    = PHASE_W'(LIM_SEARCH);
        line_inc = 1'b0;
        line_clr = 1'b0;
        unique case (state_q)
            MODE_SEARCH: begin
                limit = PHASE_W'(LIM_SEARCH);
                if (expire) state_d = MODE_FETCH;
            end
            MODE_FETCH: begin
                limit = PHASE_W'(LIM_FETCH);
                if (expire) state_d = MODE_HBLANK;
            end
            MODE_HBLANK: begin
                limit    = PHASE_W'(LIM_HBLANK);
                line_inc = expire;
                if (expire) state_d = last_line ? MODE_VBLANK : MODE_SEARCH;
            end
            MODE_VBLANK: begin
                limit    = PHASE_W'(LIM_VBLANK);
                line_clr = expire;
                if (expire) state_d = MODE_SEARCH;
            end
            default: state_d = state_q;
        endcase
    end

    // output registers: entry pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            hb_pulse <= 1'b0;
            vb_pulse <= 1'b0;
        end else begin
            hb_pulse <= (state_q == MODE_FETCH)  && (state_d == MODE_HBLANK);
            vb_pulse <= (state_q == MODE_HBLANK) && (state_d == MODE_VBLANK);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
    import scanline_seq_pkg::*;
#(
    parameter int CYC_W      = 8,
    parameter int LINE_W     = 8,
    parameter int VIS_LINES  = 143,
    parameter int LIM_SEARCH = 80,
    parameter int LIM_FETCH  = 172,
    parameter int LIM_HBLANK = 204,
    parameter int LIM_VBLANK = 4560
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [CYC_W-1:0]  step_cycles,
    output logic [1:0]        mode,
    output logic [LINE_W-1:0] line,
    output logic              hblank_start,
    output logic              vblank_start
);

    localparam int PHASE_W = $clog2(LIM_VBLANK + (1 << CYC_W) + 1) + 1;

    logic               expire;
    logic               last_line;
    logic               line_inc;
    logic               line_clr;
    logic [PHASE_W-1:0] limit;
    scan_mode_e         state;

    scan_phase_acc #(
        .CYC_W  (CYC_W),
        .PHASE_W(PHASE_W)
    ) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (step_en),
        .inc   (step_cycles),
        .limit (limit),
        .expire(expire)
    );

    scan_line_ctr #(
        .LINE_W   (LINE_W),
        .VIS_LINES(VIS_LINES)
    ) u_line (
        .clk (clk),
        .rst (rst),
        .inc (line_inc),
        .clr (line_clr),
        .line(line),
        .last(last_line)
    );

    scan_mode_fsm #(
        .PHASE_W   (PHASE_W),
        .LIM_SEARCH(LIM_SEARCH),
        .LIM_FETCH (LIM_FETCH),
        .LIM_HBLANK(LIM_HBLANK),
        .LIM_VBLANK(LIM_VBLANK)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .last_line(last_line),
        .state    (state),
        .limit    (limit),
        .line_inc (line_inc),
        .line_clr (line_clr),
        .hb_pulse (hblank_start),
        .vb_pulse (vblank_start)
    );

    assign mode = state;

endmodule

// File: rtl/scanline_seq_chk.sv
module scanline_seq_chk #(
    parameter int LINE_W    = 8,
    parameter int VIS_LINES = 143
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] line,
    input logic              hblank_start,
    input logic              vblank_start
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(mode) && $stable(line)));

    // R9
    hb_entry_chk: assert property (@(posedge clk) disable iff (rst)
        hblank_start |-> (mode == 2'd0 && $past(mode) == 2'd3));

    // R10
    vb_entry_chk: assert property (@(posedge clk) disable iff (rst)
        vblank_start |-> (mode == 2'd1 && $past(mode) == 2'd0
                          && line == LINE_W'(VIS_LINES)));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hblank_start, vblank_start}));

    // R5
    line_move_chk: assert property (@(posedge clk) disable iff (rst)
        (line != $past(line)) |-> ($past(mode) == 2'd0 || $past(mode) == 2'd1));

    // R6
    line_bound_chk: assert property (@(posedge clk) disable iff (rst)
        line <= LINE_W'(VIS_LINES));

endmodule

bind scanline_seq scanline_seq_chk #(
    .LINE_W   (LINE_W),
    .VIS_LINES(VIS_LINES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_en     (step_en),
    .mode        (mode),
    .line        (line),
    .hblank_start(hblank_start),
    .vblank_start(vblank_start)
);

// File: tb/scanline_seq_test.sv
module scanline_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [7:0] step_cycles = 8'd0;
    logic [1:0] mode;
    logic [7:0] line;
    logic       hblank_start;
    logic       vblank_start;

    int n_run  = 0;
    int n_fail = 0;

    scanline_seq uut (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .step_cycles (step_cycles),
        .mode        (mode),
        .line        (line),
        .hblank_start(hblank_start),
        .vblank_start(vblank_start)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one step, outputs sampled at the falling edge after the update
    task automatic step(input int cyc);
        @(negedge clk);
        step_en     = 1'b1;
        step_cycles = 8'(cyc);
        @(negedge clk);
        step_en     = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mode", mode, 2);
        chk("R1", "line", line, 0);
        chk("R1", "hblank_start", hblank_start, 0);
        chk("R1", "vblank_start", vblank_start, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        step_en     = 1'b0;
        step_cycles = 8'd255;
        repeat (6) @(negedge clk);
        chk("R2", "mode idle", mode, 2);
        chk("R2", "line idle", line, 0);
        chk("R2", "no pulse idle", int'(hblank_start | vblank_start), 0);
    endtask

    task automatic t_threshold();
        step(80);
        chk("R3", "equal to search limit keeps mode", mode, 2);
        step(0);
        chk("R3", "zero step keeps mode", mode, 2);
        step(1);
        chk("R4", "search to fetch", mode, 3);
        step(100);
        step(72);
        chk("R3", "equal to fetch limit keeps mode", mode, 3);
        step(1);
        chk("R4", "fetch to hblank", mode, 0);
        chk("R9", "hblank pulse high", hblank_start, 1);
        idle();
        chk("R9", "hblank pulse one cycle", hblank_start, 0);
        step(204);
        chk("R3", "equal to hblank limit keeps mode", mode, 0);
        chk("R5", "line before hblank exit", line, 0);
        step(1);
        chk("R5", "hblank to search", mode, 2);
        chk("R5", "line increments", line, 1);
    endtask

    task automatic t_excess();
        step(250);
        chk("R8", "big step leaves search", mode, 3);
        step(172);
        chk("R8", "excess dropped, fetch held", mode, 3);
        step(1);
        chk("R8", "fetch exits after one more", mode, 0);
        step(255);
        chk("R5", "next line in search", mode, 2);
        chk("R5", "line two", line, 2);
    endtask

    task automatic t_frame_end();
        for (int i = 2; i < 142; i++) begin
            step(255);
            step(255);
            step(255);
        end
        chk("R5", "last visible line", line, 142);
        chk("R5", "last visible mode", mode, 2);
        step(255);
        step(255);
        chk("R10", "no vblank pulse in hblank", vblank_start, 0);
        step(255);
        chk("R6", "enters vblank", mode, 1);
        chk("R6", "line at limit", line, 143);
        chk("R10", "vblank pulse high", vblank_start, 1);
        chk("R9", "no hblank pulse at vblank", hblank_start, 0);
        idle();
        chk("R10", "vblank pulse one cycle", vblank_start, 0);
    endtask

    task automatic t_vblank();
        for (int i = 0; i < 17; i++) step(255);
        step(225);
        chk("R7", "vblank held at limit", mode, 1);
        chk("R7", "line held in vblank", line, 143);
        step(1);
        chk("R7", "vblank to search", mode, 2);
        chk("R7", "line back to zero", line, 0);
        chk("R10", "no pulse on frame start", int'(hblank_start | vblank_start), 0);
        step(255);
        chk("R4", "new frame runs", mode, 3);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_threshold();
        t_excess();
        t_frame_end();
        t_vblank();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule